// File: doc/BRIEF.md
# EDO DRAM Page-Mode Read Sequencer

This block drives the row strobe, column strobe and multiplexed address lines of an EDO DRAM for page-mode read bursts. It runs from a clock at twice the memory-clock rate, so every strobe edge can land on a whole or a half memory-clock boundary. One such fast clock period is called a tick below. Interval k is the tick that begins at the k-th rising edge after the edge that accepted the request, which is interval 0.

A host presents a row address, a starting column and a burst length of 1 to 4 words. It holds `reqValid` high and the request is taken on a clock edge where `reqReady` is high. The sequencer first places the row on the address lines and lowers the row strobe after a programmable setup time. After a programmable row-to-column delay it issues one column strobe per memory clock, stepping the column address by one each time. It captures each data word late, using the extended hold of EDO parts, and presents the word with a one-tick valid pulse. A done pulse marks the last word.

Three configuration inputs set the timing: a cycle-time field, a row-timing field and a fast row-to-column bit. The sequencer latches them when it accepts a request. `reqReady` returns only after the row-strobe precharge and the minimum random cycle have both run out.

Top module: `edo_read_seq`

## Requirements
- R1: After reset, `rasN` and `casN` are 1, `rdValid` and `done` are 0, and `reqReady` is 1.
- R2: Row setup time S depends on `rowSel`: 01 gives 4 ticks, 10 gives 3 ticks, and 00 or 11 gives 5 ticks. `memAddr` holds the row in interval 0, and `rasN` first goes low in interval S.
- R3: Row-to-column delay D depends on `rowSel` and `rcdFast`. With `rowSel` 01, D is 3 ticks whatever `rcdFast` is. With any other `rowSel`, D is 2 ticks if `rcdFast` is 1 and 4 ticks if it is 0. The first column strobe goes low in interval S+D.
- R4: A request with `reqLenM1` = n-1 produces exactly n column-strobe pulses. Each pulse is low for one tick and pulses repeat every 2 ticks, all while `rasN` is low. During pulse i, `memAddr` equals (start column + i) modulo 2^ADDR_W. The address is also the same in the tick before each low tick, so it changes only while `casN` is high.
- R5: Word i is sampled on the edge that starts interval S+D+2+2i. It appears on `rdData` with `rdValid` high in that interval only, and it equals what the memory drove after pulse i.
- R6: `rasN` rises in interval S+D+2n, two ticks after the last column strobe falls. `done` pulses in that same interval, together with the last `rdValid`.
- R7: Precharge time P depends on `rowSel`: 01 gives 3 ticks, 10 gives 2 ticks, and 00 or 11 gives 4 ticks. `reqReady` is low from interval 0 and returns in interval max(S+D+2n+P, C).
- R8: Minimum cycle C depends on `cycleSel`: 01 gives 8 ticks, 10 gives 6 ticks, and 00 or 11 gives 10 ticks.
- R9: While `reqReady` is low, `reqValid` and changes on the request and configuration inputs have no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer can accept a request |
| reqRow | input | ADDR_W | Row address |
| reqCol | input | ADDR_W | Starting column address |
| reqLenM1 | input | 2 | Burst length minus one |
| cycleSel | input | 2 | Minimum random cycle code |
| rowSel | input | 2 | Row setup / precharge / delay code |
| rcdFast | input | 1 | Short row-to-column delay option |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| memAddr | output | ADDR_W | Multiplexed row/column address |
| memData | input | DATA_W | Read data from memory |
| rdValid | output | 1 | Captured word valid, one tick per word |
| rdData | output | DATA_W | Captured word |
| done | output | 1 | Last word of the burst |

## Verification
In the last interval of a burst three things happen at once: the final data capture, the done pulse and the rise of the row strobe. The sweep covers every combination of cycle code, row code, delay bit and burst length. For each burst it measures the interval of each of these events separately and compares it with S+D+2n worked out from the code tables. The `reqReady` return can also coincide with the end of the minimum cycle rather than the end of the precharge. Short settings combined with the longest cycle code make the cycle limit the binding one, and the bench compares the measured return interval with the larger of the two bounds.

// File: rtl/edo_rd_pkg.sv
package edo_rd_pkg;
  localparam int MAX_BURST = 4;
  localparam int LEN_W = $clog2(MAX_BURST);
  // longest span: setup 5 + delay 4 + 2 per word + precharge 4
  localparam int MAX_SPAN = 5 + 4 + 2 * MAX_BURST + 4;
  localparam int CNT_W = $clog2(MAX_SPAN + 2);

  typedef enum logic {ST_IDLE, ST_BUSY} seq_state_t;

  typedef struct packed {
    logic             accept;
    logic             rasLo;
    logic             casLo;
    logic             selCol;
    logic [LEN_W-1:0] colIdx;
    logic             capture;
    logic             finish;
  } edo_strobe_t;
endpackage

// File: rtl/edo_rd_ctrl.sv
module edo_rd_ctrl
  import edo_rd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic [LEN_W-1:0]     reqLenM1,
  input  logic [1:0]           cycleSel,
  input  logic [1:0]           rowSel,
  input  logic                 rcdFast,
  output logic                 reqReady,
  output edo_strobe_t          strobe
);
  seq_state_t state;
  logic [CNT_W-1:0] tick, sT, dT, pT, cT;
  logic [LEN_W-1:0] lenM1;
  logic [CNT_W-1:0] k, rcdEnd, rasRise, prechEnd, readyAt, off, idxRaw;
  logic             accept, inRas, inCol, evenPhase;

  function automatic logic [CNT_W-1:0] setupTicks(input logic [1:0] sel);
    case (sel)
      2'b01:   setupTicks = CNT_W'(4);
      2'b10:   setupTicks = CNT_W'(3);
      default: setupTicks = CNT_W'(5);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] rcdTicks(input logic [1:0] sel, input logic fast);
    if (sel == 2'b01) rcdTicks = CNT_W'(3);
    else              rcdTicks = fast ? CNT_W'(2) : CNT_W'(4);
  endfunction

  function automatic logic [CNT_W-1:0] prechTicks(input logic [1:0] sel);
    case (sel)
      2'b01:   prechTicks = CNT_W'(3);
      2'b10:   prechTicks = CNT_W'(2);
      default: prechTicks = CNT_W'(4);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] cycTicks(input logic [1:0] sel);
    case (sel)
      2'b01:   cycTicks = CNT_W'(8);
      2'b10:   cycTicks = CNT_W'(6);
      default: cycTicks = CNT_W'(10);
    endcase
  endfunction

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  // interval index that the next edge starts
  assign k        = tick + CNT_W'(1);
  assign rcdEnd   = sT + dT;
  assign rasRise  = rcdEnd + ((CNT_W'(lenM1) + CNT_W'(1)) << 1);
  assign prechEnd = rasRise + pT;
  assign readyAt  = (prechEnd > cT) ? prechEnd : cT;
  assign off      = k + CNT_W'(1) - rcdEnd;
  assign idxRaw   = off >> 1;
  assign inRas    = (k >= sT) && (k < rasRise);
  assign inCol    = (k + CNT_W'(1) >= rcdEnd) && (k < rasRise);
  assign evenPhase = ~off[0];

  always_comb begin
    strobe = '0;
    if (state == ST_IDLE) begin
      strobe.accept = accept;
    end else begin
      strobe.rasLo   = inRas;
      strobe.selCol  = inCol;
      strobe.colIdx  = (idxRaw > CNT_W'(lenM1)) ? lenM1 : idxRaw[LEN_W-1:0];
      strobe.casLo   = inRas && (k >= rcdEnd) && !evenPhase;
      strobe.capture = (k >= rcdEnd + CNT_W'(2)) && (k <= rasRise) && !evenPhase;
      strobe.finish  = (k == rasRise);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tick  <= '0;
      sT    <= '0;
      dT    <= '0;
      pT    <= '0;
      cT    <= '0;
      lenM1 <= '0;
    end else if (state == ST_IDLE) begin
      if (accept) begin
        state <= ST_BUSY;
        tick  <= '0;
        sT    <= setupTicks(rowSel);
        dT    <= rcdTicks(rowSel, rcdFast);
        pT    <= prechTicks(rowSel);
        cT    <= cycTicks(cycleSel);
        lenM1 <= reqLenM1;
      end
    end else begin
      tick <= k;
      if (k == readyAt) state <= ST_IDLE;
    end
  end

  // R9: once taken, a request blocks further acceptance on the next tick
  p_accept_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !reqReady);
  // R7: a burst never outlives its ready point
  p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |-> (tick < readyAt));
  // R4: column strobe only inside a row-strobe window
  p_cas_in_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.casLo |-> strobe.rasLo);
endmodule

// File: rtl/edo_rd_dpath.sv
module edo_rd_dpath
  import edo_rd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  edo_strobe_t       strobe,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  input  logic [DATA_W-1:0] memData,
  output logic              rasN,
  output logic              casN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);
  logic [ADDR_W-1:0] rowReg, colReg, addrNext;

  always_comb begin
    if (strobe.accept)      addrNext = reqRow;
    else if (strobe.selCol) addrNext = colReg + ADDR_W'(strobe.colIdx);
    else                    addrNext = rowReg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowReg  <= '0;
      colReg  <= '0;
      memAddr <= '0;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      rdValid <= 1'b0;
      rdData  <= '0;
      done    <= 1'b0;
    end else begin
      if (strobe.accept) begin
        rowReg <= reqRow;
        colReg <= reqCol;
      end
      memAddr <= addrNext;
      rasN    <= ~strobe.rasLo;
      casN    <= ~strobe.casLo;
      rdValid <= strobe.capture;
      done    <= strobe.finish;
      if (strobe.capture) rdData <= memData;
    end
  end

  // R4: address set a tick before the strobe falls and held while low
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !casN |-> $stable(memAddr));
  // R4: each column pulse is one tick wide
  p_cas_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(casN) |=> casN);
  // R6: done accompanies the last word and a raised row strobe
  p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rdValid && rasN && $rose(rasN)));
  // R5: words appear one tick at a time
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |=> !rdValid);
endmodule

// File: rtl/edo_read_seq.sv
module edo_read_seq
  import edo_rd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  input  logic [1:0]        reqLenM1,
  input  logic [1:0]        cycleSel,
  input  logic [1:0]        rowSel,
  input  logic              rcdFast,
  output logic              rasN,
  output logic              casN,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);
  edo_strobe_t strobe;

  edo_rd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqLenM1 (reqLenM1[LEN_W-1:0]),
    .cycleSel (cycleSel),
    .rowSel   (rowSel),
    .rcdFast  (rcdFast),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  edo_rd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .reqRow  (reqRow),
    .reqCol  (reqCol),
    .memData (memData),
    .rasN    (rasN),
    .casN    (casN),
    .memAddr (memAddr),
    .rdValid (rdValid),
    .rdData  (rdData),
    .done    (done)
  );

  // R7: precharge keeps the row strobe high whenever a request can be taken
  p_ready_ras_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (rasN && casN));
endmodule

// File: tb/edo_read_seq_test.sv
module edo_read_seq_test;
  localparam int TCLK   = 10;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqRow = '0, reqCol = '0;
  logic [1:0] reqLenM1 = '0, cycleSel = '0, rowSel = '0;
  logic rcdFast = 1'b0;
  logic rasN, casN, rdValid, done;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData = '0, rdData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int curRow = 0;

  edo_read_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqRow(reqRow), .reqCol(reqCol), .reqLenM1(reqLenM1),
    .cycleSel(cycleSel), .rowSel(rowSel), .rcdFast(rcdFast),
    .rasN(rasN), .casN(casN), .memAddr(memAddr), .memData(memData),
    .rdValid(rdValid), .rdData(rdData), .done(done));

  always #(TCLK/2) clk = ~clk;

  function automatic int pat(input int row, input int col);
    return ((row * 37) ^ (col * 11) ^ 'h5A3C) & 'hFFFF;
  endfunction

  // memory model: drives the word for the strobed column, held afterwards
  always @(negedge clk) if (!casN) memData <= DATA_W'(pat(curRow, int'(memAddr)));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic runOne(input int cyc, input int rs, input int fast, input int len,
                        input int row, input int col, input bit junk);
    int s, d, p, c, n, rise, readyExp;
    int firstRas, firstCas, casCnt, dataCnt, doneK, riseK, readyK, prevRas;
    bit addrOk, spaceOk, dataOk, dataTimeOk;
    s = (rs == 1) ? 4 : (rs == 2) ? 3 : 5;
    d = (rs == 1) ? 3 : (fast != 0 ? 2 : 4);
    p = (rs == 1) ? 3 : (rs == 2) ? 2 : 4;
    c = (cyc == 1) ? 8 : (cyc == 2) ? 6 : 10;
    n = len;
    rise = s + d + 2 * n;
    readyExp = (rise + p > c) ? rise + p : c;
    firstRas = -1; firstCas = -1; casCnt = 0; dataCnt = 0;
    doneK = -1; riseK = -1; readyK = -1; prevRas = 1;
    addrOk = 1; spaceOk = 1; dataOk = 1; dataTimeOk = 1;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqRow = ADDR_W'(row); reqCol = ADDR_W'(col);
    reqLenM1 = 2'(len - 1); cycleSel = 2'(cyc); rowSel = 2'(rs); rcdFast = fast[0];
    curRow = row;
    @(negedge clk);
    if (junk) begin
      reqRow = ~reqRow; reqCol = ~reqCol; reqLenM1 = ~reqLenM1;
      cycleSel = ~cycleSel; rowSel = ~rowSel; rcdFast = ~rcdFast;
    end else reqValid = 1'b0;
    for (int k = 0; k < 64; k++) begin
      if (k == 0) begin
        check(memAddr == ADDR_W'(row), "R2 row on address", int'(memAddr), row);
        check(!reqReady, "R7 ready drops", int'(reqReady), 0);
      end
      if (!rasN && firstRas < 0) firstRas = k;
      if (prevRas == 0 && rasN) riseK = k;
      if (!casN) begin
        if (firstCas < 0) firstCas = k;
        if (rasN) spaceOk = 0;
        if ((k - firstCas) != 2 * casCnt) spaceOk = 0;
        if (int'(memAddr) != ((col + casCnt) % (1 << ADDR_W))) addrOk = 0;
        casCnt++;
      end
      if (rdValid) begin
        if (k != s + d + 2 + 2 * dataCnt) dataTimeOk = 0;
        if (int'(rdData) != pat(row, (col + dataCnt) % (1 << ADDR_W))) dataOk = 0;
        dataCnt++;
      end
      if (done) doneK = k;
      if (reqReady && k > 0) begin
        readyK = k;
        reqValid = 1'b0;
        break;
      end
      prevRas = rasN;
      @(negedge clk);
    end
    check(firstRas == s, "R2 row setup", firstRas, s);
    check(firstCas == s + d, "R3 row-to-column delay", firstCas, s + d);
    check(casCnt == n && spaceOk, "R4 column pulses", casCnt, n);
    check(addrOk, junk ? "R9 column addresses" : "R4 column addresses", int'(addrOk), 1);
    check(dataCnt == n && dataTimeOk, "R5 capture timing", dataCnt, n);
    check(dataOk, junk ? "R9 captured data" : "R5 captured data", int'(dataOk), 1);
    check(riseK == rise, "R6 row strobe rise", riseK, rise);
    check(doneK == rise, "R6 done", doneK, rise);
    check(readyK == readyExp, (c > rise + p) ? "R8 cycle bound" : "R7 precharge bound",
          readyK, readyExp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rasN && casN, "R1 strobes idle", int'({rasN, casN}), 3);
    check(!rdValid && !done, "R1 no output", int'({rdValid, done}), 0);
    check(reqReady, "R1 ready", int'(reqReady), 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int cy = 0; cy < 4; cy++)
      for (int rs = 0; rs < 4; rs++)
        for (int f = 0; f < 2; f++)
          for (int ln = 1; ln <= 4; ln++)
            runOne(cy, rs, f, ln, (cy * 97 + rs * 31 + ln) % 512,
                   (cy * 41 + rs * 13 + f * 7 + ln * 3 + 480) % 512, 1'b0);
    // R9: request and configuration inputs move during bursts
    runOne(0, 0, 0, 4, 300, 510, 1'b1);
    runOne(2, 2, 1, 3, 17, 255, 1'b1);
    runOne(1, 1, 0, 2, 444, 511, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule